// File: doc/BRIEF.md
# Look-ahead XY mesh route unit

This block sits on one input port of a two-dimensional mesh router and rewrites the routing field of a granted flit. It computes that field one hop ahead. The flit arrives already carrying the output port that the current router must use. The unit moves the local router's coordinates one hop in that direction, which gives the position of the downstream router. It then runs dimension-order routing for that downstream router: X is resolved first, then Y, and ejection happens at the destination. The resulting port is written back into the flit before the flit enters the crossbar.

The logic is purely combinational, so it can run alongside switch allocation without adding a pipeline stage. One copy is instantiated per input port. Only flits that open a packet are rewritten. Middle and closing flits follow the path that their packet's opening flit has already fixed, and they pass through untouched.

The flit is a flat vector, least significant bit first:
- a 2-bit kind field in bits [1:0]: opening=0, middle=1, closing=2, single-flit=3;
- a 3-bit hop field in bits [4:2]: local=0, north=1, south=2, east=3, west=4;
- destination X in the next COORD_W bits;
- destination Y in the COORD_W bits after that;
- the payload in the remaining bits.

East increases X and north increases Y. A generate option can invert the Y sense.

Top module: `lar_route_unit`

## Requirements
- R1: For kind 0 (opening) and kind 3 (single-flit), the output equals the input except the hop field [4:2], which holds the next router's port.
- R2: For kind 1 (middle) and kind 2 (closing), the output equals the input in every bit.
- R3: When the incoming hop field is local (0), the flit is passed through unchanged, whatever its kind.
- R4: The next router's position is the local position stepped by one: hop east (3) gives X+1, west (4) gives X-1, north (1) gives Y+1, south (2) gives Y-1.
- R5: When the next router's position equals the destination, the written hop field is local (0).
- R6: When the next router's X differs from the destination X, the written hop field is east (3) if the destination X is larger, otherwise west (4).
- R7: When the X values match but the Y values differ, the written hop field is north (1) if the destination Y is larger, otherwise south (2).
- R8: Incoming hop codes 5, 6 and 7 are not directions, and such flits pass through unchanged.
- R9: The output follows the input within the same cycle, with no register on the path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flit_i | input | 2*COORD_W+5+PAY_W | Granted flit carrying the current router's output port |
| here_x_i | input | COORD_W | X coordinate of this router |
| here_y_i | input | COORD_W | Y coordinate of this router |
| flit_o | output | 2*COORD_W+5+PAY_W | Flit with the look-ahead port written in |

## Verification
Every source and destination pair of a 4x4 region is walked hop by hop, and the port produced at each hop is compared against an XY walk kept in the bench. Straight-line paths separate the X-step and Y-step cases. L-shaped paths test the single turn from X to Y. Paths whose last hop lands on the destination test ejection. Separate patterns apply middle and closing flits with random payloads, local hop codes, and the illegal hop codes 5 to 7, each on every router of the region. These patterns tell wrongful rewriting apart from correct pass-through.

// File: rtl/lar_pkg.sv
package lar_pkg;
   typedef logic [2:0] hop_t;
   typedef logic [1:0] kind_t;

   localparam int KIND_W = 2;
   localparam int HOP_W  = 3;

   localparam hop_t HOP_LOCAL = 3'd0;
   localparam hop_t HOP_NORTH = 3'd1;
   localparam hop_t HOP_SOUTH = 3'd2;
   localparam hop_t HOP_EAST  = 3'd3;
   localparam hop_t HOP_WEST  = 3'd4;

   localparam kind_t KIND_OPEN  = 2'd0;
   localparam kind_t KIND_MID   = 2'd1;
   localparam kind_t KIND_CLOSE = 2'd2;
   localparam kind_t KIND_SOLO  = 2'd3;
endpackage

// File: rtl/lar_hop_step.sv
module lar_hop_step
   import lar_pkg::*;
#(
   parameter int COORD_W  = 3,
   parameter bit NORTH_UP = 1'b1
) (
   input  logic [COORD_W-1:0] x_i,
   input  logic [COORD_W-1:0] y_i,
   input  hop_t               hop_i,
   output logic [COORD_W-1:0] nx_o,
   output logic [COORD_W-1:0] ny_o,
   output logic               move_o
);
   localparam logic [COORD_W-1:0] ONE = {{(COORD_W-1){1'b0}}, 1'b1};

   logic [COORD_W-1:0] y_north, y_south;

   generate
      if (NORTH_UP) begin : g_north_inc
         assign y_north = y_i + ONE;
         assign y_south = y_i - ONE;
      end else begin : g_north_dec
         assign y_north = y_i - ONE;
         assign y_south = y_i + ONE;
      end
   endgenerate

   always_comb begin
      nx_o   = x_i;
      ny_o   = y_i;
      move_o = 1'b1;
      case (hop_i)
         HOP_EAST:  nx_o = x_i + ONE;
         HOP_WEST:  nx_o = x_i - ONE;
         HOP_NORTH: ny_o = y_north;
         HOP_SOUTH: ny_o = y_south;
         default:   move_o = 1'b0;
      endcase
   end

   // R4
   always_comb begin
      one_axis_chk: assert (!move_o || ((nx_o == x_i) != (ny_o == y_i)))
         else $error("step changed both or neither axis");
   end
endmodule

// File: rtl/lar_xy_decide.sv
module lar_xy_decide
   import lar_pkg::*;
#(
   parameter int COORD_W  = 3,
   parameter bit NORTH_UP = 1'b1
) (
   input  logic [COORD_W-1:0] at_x_i,
   input  logic [COORD_W-1:0] at_y_i,
   input  logic [COORD_W-1:0] dst_x_i,
   input  logic [COORD_W-1:0] dst_y_i,
   output hop_t               hop_o
);
   logic x_done, y_done, go_east, y_above;

   assign x_done  = (at_x_i == dst_x_i);
   assign y_done  = (at_y_i == dst_y_i);
   assign go_east = (dst_x_i > at_x_i);
   assign y_above = (dst_y_i > at_y_i);

   always_comb begin
      if (!x_done)
         hop_o = go_east ? HOP_EAST : HOP_WEST;
      else if (!y_done)
         hop_o = (y_above == NORTH_UP) ? HOP_NORTH : HOP_SOUTH;
      else
         hop_o = HOP_LOCAL;
   end

   // R6
   always_comb begin
      x_first_chk: assert (!(hop_o == HOP_NORTH || hop_o == HOP_SOUTH) || at_x_i == dst_x_i)
         else $error("Y move chosen before X resolved");
   end
   // R5
   always_comb begin
      eject_chk: assert ((hop_o == HOP_LOCAL) == (at_x_i == dst_x_i && at_y_i == dst_y_i))
         else $error("eject decision mismatch");
   end
endmodule

// File: rtl/lar_route_unit.sv
module lar_route_unit
   import lar_pkg::*;
#(
   parameter int COORD_W  = 3,
   parameter int PAY_W    = 16,
   parameter bit NORTH_UP = 1'b1,
   localparam int HOP_LO  = KIND_W,
   localparam int DX_LO   = HOP_LO + HOP_W,
   localparam int DY_LO   = DX_LO + COORD_W,
   localparam int PAY_LO  = DY_LO + COORD_W,
   localparam int FLIT_W  = PAY_LO + PAY_W
) (
   input  logic [FLIT_W-1:0]  flit_i,
   input  logic [COORD_W-1:0] here_x_i,
   input  logic [COORD_W-1:0] here_y_i,
   output logic [FLIT_W-1:0]  flit_o
);
   generate
      if (COORD_W < 1 || COORD_W > 16) begin : g_bad_coord
         $error("COORD_W out of range");
      end
      if (PAY_W < 1) begin : g_bad_pay
         $error("PAY_W must be positive");
      end
   endgenerate

   kind_t              kind;
   hop_t               cur_hop, next_hop;
   logic [COORD_W-1:0] dst_x, dst_y, nx, ny;
   logic               moves, opens;

   assign kind    = flit_i[HOP_LO-1:0];
   assign cur_hop = flit_i[DX_LO-1:HOP_LO];
   assign dst_x   = flit_i[DY_LO-1:DX_LO];
   assign dst_y   = flit_i[PAY_LO-1:DY_LO];
   assign opens   = (kind == KIND_OPEN) || (kind == KIND_SOLO);

   lar_hop_step #(.COORD_W(COORD_W), .NORTH_UP(NORTH_UP)) u_step (
      .x_i    (here_x_i),
      .y_i    (here_y_i),
      .hop_i  (cur_hop),
      .nx_o   (nx),
      .ny_o   (ny),
      .move_o (moves)
   );

   lar_xy_decide #(.COORD_W(COORD_W), .NORTH_UP(NORTH_UP)) u_decide (
      .at_x_i  (nx),
      .at_y_i  (ny),
      .dst_x_i (dst_x),
      .dst_y_i (dst_y),
      .hop_o   (next_hop)
   );

   always_comb begin
      flit_o = flit_i;
      if (opens && moves)
         flit_o[DX_LO-1:HOP_LO] = next_hop;
   end

   // R2
   always_comb begin
      body_pass_chk: assert (opens || flit_o == flit_i)
         else $error("non-opening flit altered");
   end
   // R1
   always_comb begin
      other_bits_chk: assert (flit_o[FLIT_W-1:DX_LO] == flit_i[FLIT_W-1:DX_LO]
                              && flit_o[HOP_LO-1:0] == flit_i[HOP_LO-1:0])
         else $error("bits outside hop field altered");
   end
   // R8
   always_comb begin
      hop_legal_chk: assert (flit_o[DX_LO-1:HOP_LO] <= HOP_WEST || flit_o == flit_i)
         else $error("illegal hop code produced");
   end
endmodule

// File: tb/lar_route_unit_test.sv
module lar_route_unit_test;
   localparam int CLK_P   = 10;
   localparam int CW      = 3;
   localparam int PW      = 16;
   localparam int FW      = 2 + 3 + 2*CW + PW;
   localparam int SIDE    = 4;

   logic          clk = 1'b0;
   logic [FW-1:0] flit;
   logic [CW-1:0] hx, hy;
   logic [FW-1:0] flit_o;
   int            checks = 0;
   int            fails  = 0;
   bit            done   = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   lar_route_unit #(.COORD_W(CW), .PAY_W(PW)) uut (
      .flit_i   (flit),
      .here_x_i (hx),
      .here_y_i (hy),
      .flit_o   (flit_o)
   );

   function automatic logic [FW-1:0] pack(int kind, int hop, int dx, int dy, logic [PW-1:0] pay);
      return {pay, dy[CW-1:0], dx[CW-1:0], hop[2:0], kind[1:0]};
   endfunction

   // XY choice at router (x,y): 0 local,1 north,2 south,3 east,4 west
   function automatic int xy_choice(int x, int y, int dx, int dy);
      if (x != dx) return (dx > x) ? 3 : 4;
      if (y != dy) return (dy > y) ? 1 : 2;
      return 0;
   endfunction

   task automatic apply(logic [FW-1:0] f, int x, int y, logic [FW-1:0] exp, string req);
      @(negedge clk);
      flit = f; hx = x[CW-1:0]; hy = y[CW-1:0];
      #(CLK_P/4);
      checks++;
      if (flit_o !== exp) begin
         fails++;
         $display("FAIL %s: got %h expected %h", req, flit_o, exp);
      end
   endtask

   task automatic walk(int sx, int sy, int dx, int dy, int kind, logic [PW-1:0] pay);
      int x = sx;
      int y = sy;
      int p = xy_choice(sx, sy, dx, dy);
      while (p != 0) begin
         int nx = x + ((p == 3) ? 1 : (p == 4) ? -1 : 0);
         int ny = y + ((p == 1) ? 1 : (p == 2) ? -1 : 0);
         int q  = xy_choice(nx, ny, dx, dy);
         // R1 R4 R5 R6 R7 R9: look-ahead port written in same cycle
         apply(pack(kind, p, dx, dy, pay), x, y, pack(kind, q, dx, dy, pay), "R1/R4/R5/R6/R7");
         x = nx; y = ny; p = q;
      end
   endtask

   initial begin
      flit = '0; hx = '0; hy = '0;
      #(CLK_P/4);
      checks++;
      // R3: all-zero start: opening flit with local hop passes unchanged
      if (flit_o !== '0) begin
         fails++;
         $display("FAIL R3: got %h expected %h", flit_o, {FW{1'b0}});
      end
      for (int sx = 0; sx < SIDE; sx++)
         for (int sy = 0; sy < SIDE; sy++)
            for (int dx = 0; dx < SIDE; dx++)
               for (int dy = 0; dy < SIDE; dy++)
                  walk(sx, sy, dx, dy, ((sx + dy) % 2 == 0) ? 0 : 3, PW'($urandom));
      for (int x = 0; x < SIDE; x++)
         for (int y = 0; y < SIDE; y++) begin
            for (int h = 1; h <= 4; h++) begin
               logic [FW-1:0] f1 = pack(1, h, 3 - x, y, PW'($urandom));
               logic [FW-1:0] f2 = pack(2, h, x, 3 - y, PW'($urandom));
               apply(f1, x, y, f1, "R2 middle");
               apply(f2, x, y, f2, "R2 closing");
            end
            for (int k = 0; k < 4; k++) begin
               logic [FW-1:0] fl = pack(k, 0, 3 - x, 3 - y, PW'($urandom));
               apply(fl, x, y, fl, "R3 local hop");
            end
            for (int h = 5; h <= 7; h++) begin
               logic [FW-1:0] fb = pack((h == 6) ? 3 : 0, h, 3 - x, 3 - y, PW'($urandom));
               apply(fb, x, y, fb, "R8 illegal hop");
            end
         end
      // R4 R7 explicit: south step from (2,3) to (2,2), dst (2,0) -> south
      apply(pack(0, 2, 2, 0, 16'hBEEF), 2, 3, pack(0, 2, 2, 0, 16'hBEEF), "R4/R7 south");
      // R6 west: west step from (3,1) to (2,1), dst (0,3) -> west
      apply(pack(3, 4, 0, 3, 16'h1234), 3, 1, pack(3, 4, 0, 3, 16'h1234), "R6 west");
      // R5: east step from (1,1) lands on dst (2,1) -> local
      apply(pack(0, 3, 2, 1, 16'hA5A5), 1, 1, pack(0, 0, 2, 1, 16'hA5A5), "R5 eject");
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(CLK_P*150000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule